// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block takes a bit-serial HDLC line and turns it into a stream of payload bytes. While receive is enabled, each bit qualified by a clock enable passes through a run-length tracker. The tracker finds flags, deletes stuffed zeros and spots abort and idle runs. A framer then aligns bytes to the most recent flag, accumulates the frame check sequence, and can drop frames whose leading address byte or bytes do not match two programmable values. Surviving bytes go into a 19-entry receive FIFO with a first-word-fall-through read port.

Every byte is held in a three-stage pipeline before it is written. When a closing flag arrives, the two bytes still held are the check sequence and are thrown away. The byte ahead of them is written with an end-of-packet tag and, if the check failed, an error tag. Four sticky status bits record idle channel, abort, end of packet and check-sequence error. One read strobe clears all of them.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset the FIFO is empty, the level is 0 and all status bits are 0. While `rx_enable` is low no bit is taken, no FIFO write happens and no status bit is set. Address comparison happens only while `addr_enable` is high.
- R2: The flag is the bit pattern 0,1,1,1,1,1,1,0 in arrival order. Every flag resets the byte boundary. Bits that arrive before the first flag are ignored, and consecutive flags only re-align.
- R3: Inside a frame, a zero that follows exactly five consecutive ones is deleted from the data.
- R4: Data bits arrive least significant bit first. Bytes are written to the FIFO in arrival order. Flags, abort runs and the two check-sequence bytes before the closing flag are never written.
- R5: The last data byte of a frame is written with `rd_eop` set, and status bit 2 (end of packet) is set when such a frame closes.
- R6: The check sequence is CRC-16, reflected, polynomial 0x8408, preset 0xFFFF, computed over all bytes including the check bytes. If the result is not 0xF0B8, or the closing flag is off the byte boundary, the last byte carries `rd_fcs_bad` and status bit 3 is set.
- R7: With `addr_enable` high, the first byte after the flag is compared with `addr_match_hi`. On a mismatch the frame is dropped with no FIFO write and no status, and the receiver hunts for the next flag.
- R8: With `addr_enable` and `addr_two_byte` high, the second byte is also compared, with `addr_match_lo`, with the same drop rule.
- R9: Seven or more consecutive ones after at least one complete byte of a frame abort it. The held bytes are discarded and status bit 1 is set. A run of ones before the first byte completes sets no abort status.
- R10: Fifteen consecutive ones set status bit 0 (idle channel).
- R11: A frame of fewer than three bytes between flags is discarded without any FIFO write or status.
- R12: The FIFO holds 19 entries. A write while it is full is dropped, and the level never exceeds 19.
- R13: Status bits are sticky. A one-cycle `stat_rd` pulse clears them all on the next edge, except that an event in the same cycle still sets its bit.
- R14: A bit is taken only on a clock where `bit_en` is high. Any number of idle clocks between bits does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive enable |
| addr_enable | input | 1 | Address filter enable |
| addr_two_byte | input | 1 | Compare a second address byte |
| addr_match_hi | input | 8 | Expected first address byte |
| addr_match_lo | input | 8 | Expected second address byte |
| bit_en | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | FIFO head data byte |
| rd_eop | output | 1 | FIFO head is the last byte of a frame |
| rd_fcs_bad | output | 1 | FIFO head closes a frame with a bad check |
| rx_empty | output | 1 | FIFO is empty |
| rx_level | output | 5 | FIFO occupancy |
| stat_rd | input | 1 | Status read strobe, clears all bits |
| stat | output | 4 | Status: [0] idle, [1] abort, [2] end of packet, [3] check error |

## Verification
The bench builds the block with its default 19-entry FIFO, which is small enough that one 24-byte frame sent with the reader stalled reaches the full state and shows the dropped tail. Frames are sent with bit enables on every clock and with gaps of two idle clocks. The payloads are chosen to force zero stuffing, including runs that end right before a check byte. Address filtering is covered in both the one-byte and two-byte depths, with matching and mismatching frames sent back to back.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int          BYTE_W    = 8;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD  = 16'hF0B8;
    localparam logic [15:0] CRC_POLY  = 16'h8408;
    localparam logic [7:0]  FLAG_PAT  = 8'h7E;

    // one FIFO entry: tags above the data byte
    typedef struct packed {
        logic              bad;
        logic              eop;
        logic [BYTE_W-1:0] data;
    } rx_entry_t;

    // per-bit result of the line tracker
    typedef struct packed {
        logic valid;
        logic bit_val;
        logic emit;
        logic flag;
        logic flag_short;
        logic abort;
    } line_ev_t;

    typedef enum logic {
        ST_HUNT,
        ST_OPEN
    } fr_state_t;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
    import hdlc_rx_pkg::*;
#(
    parameter int STUFF_ONES = 5,
    parameter int ABORT_ONES = 7,
    parameter int IDLE_ONES  = 15
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     bit_en,
    input  logic     bit_in,
    output line_ev_t ev,
    output logic     idle_ev
);

    localparam int RUN_W = $clog2(IDLE_ONES + 1);
    localparam int HIST  = 7;

    logic [RUN_W-1:0] ones_q;
    logic [HIST-1:0]  raw_q;
    logic [HIST-1:0]  del_q;
    logic             del_now;

    always_comb begin
        del_now       = !bit_in && (ones_q == RUN_W'(STUFF_ONES));
        ev.valid      = enable && bit_en;
        ev.bit_val    = bit_in;
        ev.emit       = !del_now;
        ev.flag       = ({raw_q, bit_in} == FLAG_PAT);
        ev.flag_short = del_q[HIST-1];
        ev.abort      = bit_in && (ones_q == RUN_W'(ABORT_ONES - 1));
        idle_ev       = ev.valid && bit_in && (ones_q == RUN_W'(IDLE_ONES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ones_q <= '0;
            raw_q  <= '0;
            del_q  <= '0;
        end else if (bit_en) begin
            raw_q <= {raw_q[HIST-2:0], bit_in};
            del_q <= {del_q[HIST-2:0], del_now};
            if (!bit_in)
                ones_q <= '0;
            else if (ones_q != RUN_W'(IDLE_ONES))
                ones_q <= ones_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int FCS_BYTES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        addr_en,
    input  logic        addr_two,
    input  logic [7:0]  addr_hi,
    input  logic [7:0]  addr_lo,
    input  line_ev_t    ev,
    output logic        wr_valid,
    output rx_entry_t   wr_entry,
    output logic        ev_eop,
    output logic        ev_fcs,
    output logic        ev_abort
);

    localparam int PIPE  = FCS_BYTES + 1;
    localparam int CNT_W = $clog2(PIPE + 1);

    fr_state_t         st_q;
    logic [2:0]        bit_cnt_q;
    logic [7:0]        sh_q;
    logic [CNT_W-1:0]  nbytes_q;
    logic [15:0]       crc_q;
    logic [7:0]        pipe_q [PIPE];

    logic [7:0]  sh_n;
    logic        byte_done;
    logic        aligned;
    logic        addr_miss;
    logic        close_bad;
    logic [15:0] crc_n;

    always_comb begin
        sh_n      = {ev.bit_val, sh_q[7:1]};
        byte_done = (bit_cnt_q == 3'd7);
        aligned   = ev.flag_short ? (bit_cnt_q == 3'd6) : (bit_cnt_q == 3'd7);
        addr_miss = addr_en &&
                    (((nbytes_q == CNT_W'(0)) && (sh_n != addr_hi)) ||
                     ((nbytes_q == CNT_W'(1)) && addr_two && (sh_n != addr_lo)));
        crc_n     = crc_byte(crc_q, sh_n);
        close_bad = (crc_q != CRC_GOOD) || !aligned;
    end

    always_ff @(posedge clk) begin
        wr_valid <= 1'b0;
        ev_eop   <= 1'b0;
        ev_fcs   <= 1'b0;
        ev_abort <= 1'b0;
        if (rst || !enable) begin
            st_q      <= ST_HUNT;
            bit_cnt_q <= '0;
            sh_q      <= '0;
            nbytes_q  <= '0;
            crc_q     <= CRC_INIT;
            wr_entry  <= '0;
            for (int i = 0; i < PIPE; i++) pipe_q[i] <= '0;
        end else if (ev.valid) begin
            if (ev.flag) begin
                if (st_q == ST_OPEN && nbytes_q == CNT_W'(PIPE)) begin
                    wr_valid      <= 1'b1;
                    wr_entry.data <= pipe_q[PIPE-1];
                    wr_entry.eop  <= 1'b1;
                    wr_entry.bad  <= close_bad;
                    ev_eop        <= 1'b1;
                    ev_fcs        <= close_bad;
                end
                st_q      <= ST_OPEN;
                bit_cnt_q <= '0;
                nbytes_q  <= '0;
                crc_q     <= CRC_INIT;
            end else if (ev.abort) begin
                if (st_q == ST_OPEN && nbytes_q != '0) ev_abort <= 1'b1;
                st_q     <= ST_HUNT;
                nbytes_q <= '0;
            end else if (st_q == ST_OPEN && ev.emit) begin
                sh_q      <= sh_n;
                bit_cnt_q <= bit_cnt_q + 3'd1;
                if (byte_done) begin
                    crc_q <= crc_n;
                    if (addr_miss) begin
                        st_q     <= ST_HUNT;
                        nbytes_q <= '0;
                    end else begin
                        if (nbytes_q == CNT_W'(PIPE)) begin
                            wr_valid      <= 1'b1;
                            wr_entry.data <= pipe_q[PIPE-1];
                            wr_entry.eop  <= 1'b0;
                            wr_entry.bad  <= 1'b0;
                        end else begin
                            nbytes_q <= nbytes_q + 1'b1;
                        end
                        for (int i = PIPE - 1; i > 0; i--) pipe_q[i] <= pipe_q[i-1];
                        pipe_q[0] <= sh_n;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH   = 19,
    parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  rx_entry_t          wr_entry,
    input  logic               rd_en,
    output rx_entry_t          rd_entry,
    output logic               empty,
    output logic [LEVEL_W-1:0] level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t          mem_q [DEPTH];
    logic [PTR_W-1:0]   wptr_q;
    logic [PTR_W-1:0]   rptr_q;
    logic [LEVEL_W-1:0] cnt_q;
    logic               wr_ok;
    logic               rd_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wr_ok    = wr_valid && (cnt_q != LEVEL_W'(DEPTH));
        rd_ok    = rd_en && (cnt_q != '0);
        rd_entry = mem_q[rptr_q];
        empty    = (cnt_q == '0);
        level    = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wptr_q] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ok) wptr_q <= ptr_inc(wptr_q);
            if (rd_ok) rptr_q <= ptr_inc(rptr_q);
            if (wr_ok && !rd_ok)      cnt_q <= cnt_q + 1'b1;
            else if (rd_ok && !wr_ok) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 19,
    parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_enable,
    input  logic               addr_enable,
    input  logic               addr_two_byte,
    input  logic [7:0]         addr_match_hi,
    input  logic [7:0]         addr_match_lo,
    input  logic               bit_en,
    input  logic               bit_in,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    output logic               rd_eop,
    output logic               rd_fcs_bad,
    output logic               rx_empty,
    output logic [LEVEL_W-1:0] rx_level,
    input  logic               stat_rd,
    output logic [3:0]         stat
);

    line_ev_t  line_ev;
    logic      line_idle;
    logic      fr_wr_valid;
    rx_entry_t fr_wr_entry;
    logic      fr_eop;
    logic      fr_fcs;
    logic      fr_abort;
    rx_entry_t head;
    logic [3:0] stat_set;
    logic [3:0] stat_q;

    hdlc_rx_line u_line (
        .clk     (clk),
        .rst     (rst),
        .enable  (rx_enable),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .ev      (line_ev),
        .idle_ev (line_idle)
    );

    hdlc_rx_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .enable   (rx_enable),
        .addr_en  (addr_enable),
        .addr_two (addr_two_byte),
        .addr_hi  (addr_match_hi),
        .addr_lo  (addr_match_lo),
        .ev       (line_ev),
        .wr_valid (fr_wr_valid),
        .wr_entry (fr_wr_entry),
        .ev_eop   (fr_eop),
        .ev_fcs   (fr_fcs),
        .ev_abort (fr_abort)
    );

    hdlc_rx_fifo #(
        .DEPTH   (FIFO_DEPTH),
        .LEVEL_W (LEVEL_W)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (fr_wr_valid),
        .wr_entry (fr_wr_entry),
        .rd_en    (rd_en),
        .rd_entry (head),
        .empty    (rx_empty),
        .level    (rx_level)
    );

    assign stat_set = {fr_fcs, fr_eop, fr_abort, line_idle};

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_rd ? 4'b0 : stat_q) | stat_set;
    end

    assign stat       = stat_q;
    assign rd_data    = head.data;
    assign rd_eop     = head.eop;
    assign rd_fcs_bad = head.bad;

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
    parameter int DEPTH   = 19,
    parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               rx_enable,
    input logic               rd_en,
    input logic               stat_rd,
    input logic [3:0]         stat,
    input logic [3:0]         stat_set,
    input logic               fifo_wr,
    input logic [LEVEL_W-1:0] level
);

    // R1: a disabled receiver produces no FIFO write on the following edge
    a_r1_no_write_disabled: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !fifo_wr);

    // R12: occupancy is bounded by the depth
    a_r12_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LEVEL_W'(DEPTH));

    // R12: a full FIFO that is not read stays full
    a_r12_full_holds: assert property (@(posedge clk) disable iff (rst)
        (level == LEVEL_W'(DEPTH)) && !rd_en |=> level == LEVEL_W'(DEPTH));

    // R13: a read with no concurrent event empties the status
    a_r13_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        stat_rd && (stat_set == 4'b0) |=> stat == 4'b0);

    // R13: without a read no status bit falls
    a_r13_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((($past(stat)) & ~stat) == 4'b0));

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(
    .DEPTH   (FIFO_DEPTH),
    .LEVEL_W (LEVEL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_enable (rx_enable),
    .rd_en     (rd_en),
    .stat_rd   (stat_rd),
    .stat      (stat),
    .stat_set  (stat_set),
    .fifo_wr   (fr_wr_valid),
    .level     (rx_level)
);

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb;

    typedef logic [7:0] bytes_t[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_enable = 1'b0;
    logic       addr_enable = 1'b0;
    logic       addr_two_byte = 1'b0;
    logic [7:0] addr_match_hi = 8'h00;
    logic [7:0] addr_match_lo = 8'h00;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_eop;
    logic       rd_fcs_bad;
    logic       rx_empty;
    logic [4:0] rx_level;
    logic [3:0] stat;

    int   n_chk = 0;
    int   n_fail = 0;
    int   tx_ones = 0;
    bit   mon_on = 1'b0;
    logic [9:0] exp_q[$];
    bytes_t fr;

    always #2 clk = ~clk;

    hdlc_rx_deframer u_dut (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .addr_enable(addr_enable),
        .addr_two_byte(addr_two_byte), .addr_match_hi(addr_match_hi),
        .addr_match_lo(addr_match_lo), .bit_en(bit_en), .bit_in(bit_in),
        .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop), .rd_fcs_bad(rd_fcs_bad),
        .rx_empty(rx_empty), .rx_level(rx_level), .stat_rd(stat_rd), .stat(stat)
    );

    function automatic void chk(input bit ok, input string req, input string what,
                                input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++)
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    // scoreboard monitor: pops one entry, then idles one cycle
    always @(negedge clk) begin
        if (rd_en) begin
            rd_en <= 1'b0;
        end else if (mon_on && !rx_empty) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R4", "unexpected FIFO entry", {rd_fcs_bad, rd_eop, rd_data}, 0);
            else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                chk({rd_fcs_bad, rd_eop, rd_data} == e, "R4 R5 R6", "FIFO entry",
                    {rd_fcs_bad, rd_eop, rd_data}, e);
            end
            rd_en <= 1'b1;
        end
    end

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic send_flag(input int gap);
        for (int i = 0; i < 8; i++) send_bit(((8'h7E >> i) & 1) != 0, gap);
        tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 0; i < 8; i++) begin
            send_bit(v[i], gap);
            tx_ones = v[i] ? tx_ones + 1 : 0;
            if (tx_ones == 5) begin
                send_bit(1'b0, gap);
                tx_ones = 0;
            end
        end
    endtask

    task automatic send_frame(input bytes_t d, input bit corrupt, input int gap, input bit store);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        foreach (d[i]) c = crc_upd(c, d[i]);
        fcs = ~c;
        if (corrupt) fcs = fcs ^ 16'h0100;
        if (store)
            foreach (d[i])
                exp_q.push_back({(i == d.size() - 1) && corrupt, i == d.size() - 1, d[i]});
        send_flag(gap);
        foreach (d[i]) send_byte(d[i], gap);
        send_byte(fcs[7:0], gap);
        send_byte(fcs[15:8], gap);
        send_flag(gap);
    endtask

    task automatic settle();
        @(negedge clk);
        bit_en = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic read_status();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rx_empty == 1'b1, "R1", "empty after reset", rx_empty, 1);
        chk(rx_level == 5'd0, "R1", "level after reset", rx_level, 0);
        chk(stat == 4'd0, "R1", "status after reset", stat, 0);

        // R1 disabled receiver ignores a valid frame
        fr = '{8'h12, 8'h34, 8'h56};
        send_frame(fr, 1'b0, 0, 1'b0);
        settle();
        chk(rx_level == 5'd0, "R1", "level while disabled", rx_level, 0);
        chk(stat == 4'd0, "R1", "status while disabled", stat, 0);

        rx_enable = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        // R2 junk before flags, repeated flags; R3 stuffing patterns
        send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
        send_flag(0);
        send_flag(0);
        fr = '{8'hA5, 8'hFF, 8'h7E, 8'h3E, 8'h1F, 8'h00};
        send_frame(fr, 1'b0, 0, 1'b1);
        settle();
        chk(exp_q.size() == 0, "R2 R3", "entries left unmatched", exp_q.size(), 0);
        chk(stat == 4'b0100, "R5", "status after good frame", stat, 4'b0100);

        // R13 read clears
        read_status();
        chk(stat == 4'd0, "R13", "status after read", stat, 0);

        // R14 idle clocks between bits
        fr = '{8'h11, 8'h22, 8'hF8, 8'h33};
        send_frame(fr, 1'b0, 2, 1'b1);
        settle();
        chk(exp_q.size() == 0, "R14", "gapped frame unmatched", exp_q.size(), 0);
        chk(stat == 4'b0100, "R14", "status after gapped frame", stat, 4'b0100);
        read_status();

        // R6 corrupted check sequence
        fr = '{8'h55, 8'h66, 8'h77};
        send_frame(fr, 1'b1, 0, 1'b1);
        settle();
        chk(exp_q.size() == 0, "R6", "bad frame unmatched", exp_q.size(), 0);
        chk(stat == 4'b1100, "R6", "status after bad frame", stat, 4'b1100);
        read_status();

        // R7 one-byte address filter
        addr_enable = 1'b1;
        addr_match_hi = 8'h40;
        fr = '{8'h40, 8'h01, 8'h02};
        send_frame(fr, 1'b0, 0, 1'b1);
        fr = '{8'h41, 8'h01, 8'h02};
        send_frame(fr, 1'b0, 0, 1'b0);
        settle();
        chk(exp_q.size() == 0 && rx_level == 5'd0, "R7", "one-byte filter", exp_q.size(), 0);
        chk(stat == 4'b0100, "R7", "status after filtered pair", stat, 4'b0100);
        read_status();

        // R8 two-byte address filter
        addr_two_byte = 1'b1;
        addr_match_lo = 8'h9C;
        fr = '{8'h40, 8'h9C, 8'h05};
        send_frame(fr, 1'b0, 0, 1'b1);
        fr = '{8'h40, 8'h9D, 8'h05};
        send_frame(fr, 1'b0, 0, 1'b0);
        settle();
        chk(exp_q.size() == 0 && rx_level == 5'd0, "R8", "two-byte filter", exp_q.size(), 0);
        chk(stat == 4'b0100, "R8", "status after filtered pair", stat, 4'b0100);
        read_status();
        addr_enable = 1'b0;
        addr_two_byte = 1'b0;

        // R11 runt of two bytes
        send_flag(0);
        send_byte(8'hC3, 0);
        send_byte(8'h5A, 0);
        send_flag(0);
        settle();
        chk(rx_level == 5'd0, "R11", "runt level", rx_level, 0);
        chk(stat == 4'd0, "R11", "runt status", stat, 0);

        // R9 abort inside a frame
        send_flag(0);
        send_byte(8'h01, 0);
        send_byte(8'h02, 0);
        send_byte(8'h03, 0);
        repeat (8) send_bit(1'b1, 0);
        send_flag(0);
        settle();
        chk(rx_level == 5'd0, "R9", "aborted frame level", rx_level, 0);
        chk(stat == 4'b0010, "R9", "abort status", stat, 4'b0010);
        read_status();

        // R10 idle run right after a flag: idle only, no abort
        send_flag(0);
        repeat (16) send_bit(1'b1, 0);
        send_flag(0);
        settle();
        chk(stat == 4'b0001, "R10", "idle status", stat, 4'b0001);
        read_status();

        // R12 fill the FIFO with the reader stalled
        mon_on = 1'b0;
        fr = {};
        for (int i = 0; i < 24; i++) fr.push_back(8'(i * 7 + 3));
        for (int i = 0; i < 19; i++) exp_q.push_back({2'b00, fr[i]});
        send_frame(fr, 1'b0, 0, 1'b0);
        settle();
        chk(rx_level == 5'd19, "R12", "level when full", rx_level, 19);
        mon_on = 1'b1;
        settle();
        chk(exp_q.size() == 0 && rx_empty, "R12", "drain after full", exp_q.size(), 0);
        read_status();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule